// File: doc/BRIEF.md
# Divider Shadow Tracker

This block rebuilds, from outside the chip, the value of a console's free-running 16-bit divider counter. The counter cannot be read over the cartridge port. The block watches the 1 MiHz phi line on a fast local clock and counts its rising edges. The console's phi output stays high while the console is held in reset. For that reason the first rising edge the block can see already has a known divider value, and the counter is seeded with that value. A program write to the divider register clears the whole 16-bit counter. The block copies that clear when it sees the write on the bus.

The block counts the phi edges between the first visible edge and the first fetch of the game entry address. The program uses this count to tell console models and boot program variants apart. When the CPU halts, phi stops but the real divider keeps running. The block then generates the missing ticks from a local timer. When phi comes back, the block snaps the timer's phase to the real edge. If phi stays away too long, the block drops its lock and ignores the bus until it sees the entry fetch again.

Top module: `div_shadow_tracker`

## Requirements
- R1: After reset, `div_count`, `div_byte` and `boot_ticks` are 0 and `locked` is 0. A phi line that is held high from reset produces no edge.
- R2: The first phi rising edge after reset loads `div_count` with 0x8001.
- R3: Each later phi rising edge adds one to `div_count`.
- R4: `div_byte` always equals bits 13 down to 6 of `div_count`.
- R5: `boot_ticks` counts phi rising edges, the first edge included, up to the first fetch of the entry address. It then stays frozen until the next reset.
- R6: A fetch is any fast-clock cycle with `addr` = 0x0100 and `wr_stb` low. A fetch after the first edge sets `locked` on the next cycle. A fetch before any edge is ignored.
- R7: While `locked` is high, a cycle with `wr_stb` high and `addr` = 0xFF04 clears all 16 bits of `div_count`. If a phi edge arrives in the same cycle, the clear wins.
- R8: While `locked` is low, writes to 0xFF04 do not change `div_count`.
- R9: While `locked` is high and phi is missing, a synthetic tick is added every 4×QUARTER_CYC fast cycles. The first synthetic tick comes QUARTER_CYC cycles after the edge was due.
- R10: A real edge restarts the local timer phase, so ticks across a halt are counted exactly once.
- R11: If GAP_CYC fast cycles pass with no real phi edge, `locked` falls. Bus writes are then ignored until a fetch relocks the block. `boot_ticks` is kept.
- R12: A phi rise shows up in `div_count` three fast-clock cycles after the input rises: two synchronizer flops, then the counter register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi_in | input | 1 | Console phi line, asynchronous to clk |
| addr | input | 16 | Cartridge address bus |
| wr_stb | input | 1 | Bus write strobe |
| div_count | output | 16 | Shadow of the 16-bit divider |
| div_byte | output | 8 | Program-visible divider byte |
| locked | output | 1 | High while the block is following the game |
| boot_ticks | output | TICK_W | Phi edges seen before the first entry fetch |

## Verification
The counter result is due on the third rising clock edge after `phi_in` goes high. The bench drives phi from tasks with a fixed phase and checks on the falling edge that follows that update. Lock changes and bus clears take effect on the first clock edge after the bus cycle, so they are checked one falling edge later. Synthetic ticks appear a quarter of a phi period after a missed edge. Halt results are therefore checked only after phi has resumed, when the exact count is settled.

// File: rtl/dst_pkg.sv
package dst_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_BOOT   = 2'd1,
    ST_FOLLOW = 2'd2,
    ST_LOST   = 2'd3
  } trk_state_t;

  localparam logic [15:0] SEED_VALUE = 16'h8001;
  localparam logic [15:0] FETCH_ADDR = 16'h0100;
  localparam logic [15:0] DIV_ADDR   = 16'hFF04;

  // program-visible window of the shadow counter
  function automatic logic [7:0] visible_byte(input logic [15:0] cnt);
    return cnt[13:6];
  endfunction

  // clear has priority over an advance
  function automatic logic [15:0] next_count(input logic [15:0] cnt,
                                             input logic clr,
                                             input logic adv);
    if (clr) return 16'd0;
    if (adv) return cnt + 16'd1;
    return cnt;
  endfunction

  // bridge period in fast cycles: a full phi period once coasting,
  // one extra crystal tick of grace for the first missing edge
  function automatic int unsigned bridge_period(input logic coasting,
                                                input int unsigned quarter);
    return coasting ? 4 * quarter : 5 * quarter;
  endfunction

endpackage

// File: rtl/dst_phi_sync.sv
module dst_phi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_in,
  output logic phi_rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
  logic [STAGES:0] chain;

  // reset to ones so that a line held high yields no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], phi_in};
  end

  assign phi_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dst_bridge_timer.sv
module dst_bridge_timer
  import dst_pkg::*;
#(
  parameter int QUARTER_CYC = 60,
  parameter int GAP_CYC     = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic real_rise,
  input  logic enable,
  output logic synth_tick,
  output logic gap_expired
);
  localparam int LEAD_CYC = 5 * QUARTER_CYC;
  localparam int CNT_W    = $clog2(LEAD_CYC + 1);
  localparam int GAP_W    = $clog2(GAP_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             coast_q;
  logic [GAP_W-1:0] gap_q;
  logic             period_done;

  always_comb begin
    period_done = (32'(cnt_q) + 32'd1) == bridge_period(coast_q, QUARTER_CYC);
  end

  // phase counter: restarted by every real edge (snap), free-running otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      coast_q <= 1'b0;
    end else if (real_rise) begin
      cnt_q   <= '0;
      coast_q <= 1'b0;
    end else if (period_done) begin
      cnt_q   <= '0;
      coast_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // saturating gap counter since the last real edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= '0;
    else if (real_rise)              gap_q <= '0;
    else if (gap_q != GAP_W'(GAP_CYC)) gap_q <= gap_q + GAP_W'(1);
  end

  assign synth_tick  = enable & period_done & ~real_rise;
  assign gap_expired = (gap_q == GAP_W'(GAP_CYC));
endmodule

// File: rtl/dst_shadow_counter.sv
module dst_shadow_counter
  import dst_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed,
  input  logic              clear,
  input  logic              advance,
  input  logic              boot_count_en,
  output logic [15:0]       count_q,
  output logic [TICK_W-1:0] boot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (seed) count_q <= SEED_VALUE;
    else           count_q <= next_count(count_q, clear, advance);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      boot_q <= '0;
    else if (seed)
      boot_q <= TICK_W'(1);
    else if (boot_count_en && advance && (boot_q != '1))
      boot_q <= boot_q + TICK_W'(1);
  end
endmodule

// File: rtl/div_shadow_tracker.sv
module div_shadow_tracker
  import dst_pkg::*;
#(
  parameter int QUARTER_CYC = 60,
  parameter int GAP_CYC     = 2000000,
  parameter int TICK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi_in,
  input  logic [15:0]       addr,
  input  logic              wr_stb,
  output logic [15:0]       div_count,
  output logic [7:0]        div_byte,
  output logic              locked,
  output logic [TICK_W-1:0] boot_ticks
);
  trk_state_t state_q, state_d;

  logic phi_rise;
  logic synth_tick;
  logic gap_expired;
  logic fetch_hit;
  logic clear_hit;
  logic seeded;
  logic seed_now;
  logic advance;

  assign fetch_hit = (addr == FETCH_ADDR) && !wr_stb;
  assign clear_hit = (state_q == ST_FOLLOW) && wr_stb && (addr == DIV_ADDR);
  assign seeded    = (state_q != ST_OFF);
  assign seed_now  = !seeded && phi_rise;
  assign advance   = phi_rise | synth_tick;
  assign locked    = (state_q == ST_FOLLOW);

  dst_phi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi_in  (phi_in),
    .phi_rise(phi_rise)
  );

  dst_bridge_timer #(.QUARTER_CYC(QUARTER_CYC), .GAP_CYC(GAP_CYC)) u_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .real_rise  (phi_rise),
    .enable     (locked),
    .synth_tick (synth_tick),
    .gap_expired(gap_expired)
  );

  dst_shadow_counter #(.TICK_W(TICK_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .seed         (seed_now),
    .clear        (clear_hit),
    .advance      (advance),
    .boot_count_en(state_q == ST_BOOT),
    .count_q      (div_count),
    .boot_q       (boot_ticks)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (phi_rise)    state_d = ST_BOOT;
      ST_BOOT:   if (fetch_hit)   state_d = ST_FOLLOW;
      ST_FOLLOW: if (gap_expired) state_d = ST_LOST;
      ST_LOST:   if (fetch_hit)   state_d = ST_FOLLOW;
      default:                    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign div_byte = visible_byte(div_count);
endmodule

// File: rtl/dst_checker.sv
module dst_checker #(
  parameter int TICK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       addr,
  input logic              wr_stb,
  input logic [15:0]       div_count,
  input logic [TICK_W-1:0] boot_ticks,
  input logic              locked,
  input logic              phi_rise,
  input logic              synth_tick,
  input logic              seeded
);
  logic bus_clear;
  assign bus_clear = locked && wr_stb && (addr == 16'hFF04);

  assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seeded && phi_rise) |=> (div_count == 16'h8001));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded && (phi_rise || synth_tick) && !bus_clear)
      |=> (div_count == $past(div_count) + 16'd1));

  assert_boot_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(boot_ticks));

  assert_lock_on_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(addr == 16'h0100 && !wr_stb));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clear |=> (div_count == 16'd0));

  assert_hold_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded && !locked && !phi_rise) |=> $stable(div_count));

  assert_synth_only_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    synth_tick |-> (locked && !phi_rise));
endmodule

bind div_shadow_tracker dst_checker #(.TICK_W(TICK_W)) u_dst_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_stb    (wr_stb),
  .div_count (div_count),
  .boot_ticks(boot_ticks),
  .locked    (locked),
  .phi_rise  (phi_rise),
  .synth_tick(synth_tick),
  .seeded    (seeded)
);

// File: tb/test_div_shadow_tracker.sv
module test_div_shadow_tracker;
  localparam int QC     = 2;
  localparam int GAP    = 400;
  localparam int TW     = 16;
  localparam int NVEC   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          phi_in = 1'b1;
  logic [15:0]   addr = 16'h0000;
  logic          wr_stb = 1'b0;
  logic [15:0]   div_count;
  logic [7:0]    div_byte;
  logic          locked;
  logic [TW-1:0] boot_ticks;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] model;
  logic [15:0] snap;

  // {clear first tick, ticks, halted periods (0 = none)}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'd3,   8'd0},
    {1'b1, 8'd2,   8'd0},
    {1'b0, 8'd1,   8'd4},
    {1'b0, 8'd2,   8'd20},
    {1'b1, 8'd1,   8'd1},
    {1'b0, 8'd100, 8'd0},
    {1'b0, 8'd40,  8'd30},
    {1'b1, 8'd4,   8'd7}
  };

  always #2 clk = ~clk;

  div_shadow_tracker #(.QUARTER_CYC(QC), .GAP_CYC(GAP), .TICK_W(TW)) i_div_shadow_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi_in    (phi_in),
    .addr      (addr),
    .wr_stb    (wr_stb),
    .div_count (div_count),
    .div_byte  (div_byte),
    .locked    (locked),
    .boot_ticks(boot_ticks)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; phi_in = 1'b1; addr = 16'h0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one phi period of 8 fast cycles, called and returning on a falling edge
  task automatic phi_tick(input bit with_clear);
    phi_in = 1'b0;
    if (with_clear) begin addr = 16'hFF04; wr_stb = 1'b1; end
    @(negedge clk);
    addr = 16'h0; wr_stb = 1'b0;
    repeat (3) @(negedge clk);
    phi_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic halt_periods(input int h);
    phi_in = 1'b0;
    repeat (8 * h) @(negedge clk);
  endtask

  task automatic fetch();
    addr = 16'h0100; wr_stb = 1'b0;
    @(negedge clk);
    addr = 16'h0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 count after reset", 32'(div_count), 0);
    check("R1 byte after reset", 32'(div_byte), 0);
    check("R1 locked after reset", 32'(locked), 0);
    check("R1 boot after reset", 32'(boot_ticks), 0);
    fetch();
    repeat (6) @(negedge clk);
    check("R6 fetch before any edge ignored", 32'(locked), 0);
    check("R1 held-high phi gives no edge", 32'(div_count), 0);

    // first visible edge, sampled for latency
    phi_in = 1'b0;
    repeat (4) @(negedge clk);
    phi_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 count not yet updated two cycles after rise", 32'(div_count), 0);
    @(negedge clk);
    check("R2 R12 seed three cycles after rise", 32'(div_count), 32'h8001);
    check("R5 boot after first edge", 32'(boot_ticks), 1);
    @(negedge clk);

    for (int k = 0; k < 4; k++) phi_tick(1'b0);
    check("R3 count after five edges", 32'(div_count), 32'h8005);
    check("R5 boot after five edges", 32'(boot_ticks), 5);
    check("R6 not locked during boot", 32'(locked), 0);
    fetch();
    check("R6 locked after fetch", 32'(locked), 1);
    model = 16'h8005;

    for (int i = 0; i < NVEC; i++) begin
      logic        clr;
      logic [7:0]  nt;
      logic [7:0]  nh;
      {clr, nt, nh} = VEC[i];
      for (int t = 0; t < int'(nt); t++) phi_tick(clr && t == 0);
      if (clr) model = 16'd0;
      model = model + 16'(nt);
      if (nh != 0) begin
        halt_periods(int'(nh));
        phi_tick(1'b0);
        model = model + 16'(nh) + 16'd1;
      end
      check("R3 R7 R9 R10 vector count", 32'(div_count), 32'(model));
      check("R4 vector byte", 32'(div_byte), 32'((model >> 6) & 16'h00FF));
      check("R6 vector locked", 32'(locked), 1);
    end
    check("R5 boot frozen while following", 32'(boot_ticks), 5);

    // clear in the same cycle as an edge reaches the counter
    phi_in = 1'b0;
    repeat (4) @(negedge clk);
    phi_in = 1'b1;
    repeat (2) @(negedge clk);
    addr = 16'hFF04; wr_stb = 1'b1;
    @(negedge clk);
    addr = 16'h0; wr_stb = 1'b0;
    check("R7 clear wins over coincident edge", 32'(div_count), 0);
    @(negedge clk);
    phi_tick(1'b0);
    check("R3 count after clear and edge", 32'(div_count), 1);

    // long gap: lose the game
    halt_periods(60);
    check("R11 lock lost after long gap", 32'(locked), 0);
    snap = div_count;
    phi_tick(1'b1);
    check("R8 write ignored while lost", 32'(div_count), 32'(snap + 16'd1));
    check("R11 boot kept after loss", 32'(boot_ticks), 5);
    fetch();
    check("R11 relock on fetch", 32'(locked), 1);
    phi_tick(1'b1);
    check("R7 clear after relock", 32'(div_count), 1);

    // second power-up with a different boot length
    do_reset();
    check("R1 count after second reset", 32'(div_count), 0);
    for (int k = 0; k < 9; k++) phi_tick(k == 2);
    check("R8 write ignored during boot", 32'(div_count), 32'h8009);
    check("R5 boot count nine", 32'(boot_ticks), 9);
    fetch();
    phi_tick(1'b0);
    check("R5 boot frozen after fetch", 32'(boot_ticks), 9);
    check("R6 locked after second fetch", 32'(locked), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule